// File: doc/BRIEF.md
# Flash Suspend-Resume Sequencer

This block runs the program/erase suspend and resume handshake with a serial flash that sits behind a command engine. Software writes a 32-bit control word that holds two trigger bits and the options. Once a trigger is set, the sequencer asks the command engine to send the matching suspend or resume command. It can then hold off for a programmable number of clock cycles. After that it polls the flash status with fresh read-status requests until the completion test passes. When the operation is confirmed, the sequencer clears the trigger bit itself. A finished suspend can also start the resume with no help from software.

The completion test is either "WIP clear" alone, or "WIP clear and masked suspend status satisfied". The masked suspend status is the status read back, one or two bytes, XORed with a 16-bit mask. A suspend needs the result to be nonzero. A resume needs it to be zero. A retry limit keeps the poll loop from running forever: once that many masked-status failures have been seen, the next failure is accepted as a pass.

The state machine has six states. Their transitions are:
- IDLE goes to ISSUE when a trigger is set. The suspend trigger has priority.
- ISSUE goes to HOLDOFF on acknowledge when the hold-off is enabled and its length is not zero. Otherwise it goes to POLL_REQ.
- HOLDOFF goes to POLL_REQ when its count runs out.
- POLL_REQ goes to POLL_WAIT on acknowledge.
- POLL_WAIT goes to DONE on a passing status, or back to POLL_REQ on a failing one.
- DONE goes to IDLE. In DONE the trigger is cleared, and the resume trigger is set if chaining is enabled.

Top module: `flash_susres_seq`

## Requirements
- R1: After reset the control word reads 0x08002000, `busy` is 0 and `cmd_req` is 0. That value gives a mask of 0x0080 and a retry limit of 4.
- R2: Control bit 1 starts a suspend and bit 0 starts a resume. `cmd_req` is raised with `cmd_op` set to 1 for a suspend or 2 for a resume. It stays raised with a stable `cmd_op` until `cmd_ack`. The trigger bit reads 1 until the operation finishes and reads 0 afterwards.
- R3: The hold-off is enabled by bit 2 for a resume and bit 3 for a suspend. When enabled, the first read-status acknowledge comes 1 + D cycles after the command acknowledge. D is `dly_val`×4, or `dly_val`×128 when `dly_x128` is 1. When the hold-off is disabled, the gap is 1 cycle.
- R4: Bit 22 selects a two-byte status read and is shown on `cmd_rd2`. With bit 22 at 0, the upper status byte is treated as zero before the XOR with the mask, which sits in bits 21:6.
- R5: With the operation's end-check bit clear, the operation completes on the first status whose bit 0 (WIP) is 0. The end-check bit is bit 23 for a resume and bit 24 for a suspend.
- R6: With the end-check bit set, a status with WIP 1 fails. A status with WIP 0 passes for a suspend when (status XOR mask) is nonzero, and for a resume when it is zero.
- R7: The retry limit N is in bits 31:25. With the end-check bit set, a WIP-0 status that fails the mask test is retried N times. Failure N+1 is accepted, so N = 0 accepts the first failure. The failure count restarts with every operation.
- R8: With bit 4 set, a completed suspend sets the resume trigger, and a resume follows with no further write.
- R9: If both triggers are set together, the suspend runs first and the resume runs after it.
- R10: While `busy` is 1, writes do not change the trigger bits, but the other fields do take the written value.
- R11: Every status poll is a separate request with `cmd_op` = 3 that is acknowledged before its status arrives on `stat_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word, including the trigger bits |
| dly_val | input | 10 | Hold-off base count |
| dly_x128 | input | 1 | Hold-off scale select: 1 gives ×128, 0 gives ×4 |
| cmd_req | output | 1 | Command request to the shifter |
| cmd_op | output | 2 | Requested command: 1 suspend, 2 resume, 3 read status |
| cmd_rd2 | output | 1 | Read-status length: 1 for two bytes, 0 for one |
| cmd_ack | input | 1 | Shifter accepts the request |
| stat_vld | input | 1 | Status data valid |
| stat_data | input | 16 | Status read back |
| busy | output | 1 | An operation is in progress |

## Verification
The hardest case to reach is the retry limit. It needs a stream of status reads in which WIP is clear but the masked suspend status keeps failing, and the number of polls must be counted exactly, including limit 0. The bench's flash responder replays a scripted list of status words, one per read request, and repeats the last word once the list runs out. The poll count shows the retry limit at the ports. The same responder logs every acknowledge with its cycle number, so the hold-off length and the suspend-then-resume order can be read from the log.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int CFG_W     = 32;
    localparam int B_RES_TRG = 0;
    localparam int B_SUS_TRG = 1;
    localparam int B_RES_WT  = 2;
    localparam int B_SUS_WT  = 3;
    localparam int B_CHAIN   = 4;
    localparam int B_RSVD    = 5;
    localparam int B_MASK_LO = 6;
    localparam int B_MASK_HI = 21;
    localparam int B_RD2     = 22;
    localparam int B_RES_END = 23;
    localparam int B_SUS_END = 24;
    localparam int B_LIM_LO  = 25;
    localparam int B_LIM_HI  = 31;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0800_2000;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SUS  = 2'd1,
        OP_RES  = 2'd2,
        OP_RDSR = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_HOLDOFF, ST_POLL_REQ, ST_POLL_WAIT, ST_DONE
    } state_t;
endpackage

// File: rtl/sr_delay_timer.sv
module sr_delay_timer #(
    parameter int DLY_W  = 10,
    parameter int SH_LO  = 2,
    parameter int SH_HI  = 7,
    localparam int CNT_W = DLY_W + SH_HI
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DLY_W-1:0] dly_val,
    input  logic             x_hi,
    output logic             zero_len,
    output logic             last
);
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        if (x_hi) total = CNT_W'(dly_val) << SH_HI;
        else      total = CNT_W'(dly_val) << SH_LO;
    end

    assign zero_len = (total == '0);
    assign last     = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= total - CNT_W'(1);
        else if (run && !last)   cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/sr_status_eval.sv
module sr_status_eval #(
    parameter int STAT_W = 16,
    localparam int HALF  = STAT_W / 2
) (
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] mask,
    input  logic              two_byte,
    input  logic              is_sus,
    output logic              wip,
    output logic              sus_ok
);
    logic [STAT_W-1:0] seen;
    logic [STAT_W-1:0] masked;

    always_comb begin
        seen   = two_byte ? stat : {{HALF{1'b0}}, stat[HALF-1:0]};
        masked = seen ^ mask;
        wip    = stat[0];
        sus_ok = is_sus ? (|masked) : ~(|masked);
    end
endmodule

// File: rtl/sr_retry_cnt.sv
module sr_retry_cnt #(
    parameter int LIM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LIM_W-1:0] limit,
    output logic             spent
);
    logic [LIM_W-1:0] fails;

    assign spent = (fails >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              fails <= '0;
        else if (clr)            fails <= '0;
        else if (inc && !spent)  fails <= fails + LIM_W'(1);
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> fails == '0); // R7
endmodule

// File: rtl/flash_susres_seq.sv
module flash_susres_seq
    import sr_pkg::*;
#(
    parameter int DLY_W  = 10,
    parameter int STAT_W = 16,
    parameter int LIM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [DLY_W-1:0]  dly_val,
    input  logic              dly_x128,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic              cmd_rd2,
    input  logic              cmd_ack,
    input  logic              stat_vld,
    input  logic [STAT_W-1:0] stat_data,
    output logic              busy
);
    state_t state, state_nx;
    logic [CFG_W-1:0] cfg_q, cfg_d;
    logic cur_sus, cur_sus_nx;
    logic tm_load, tm_zero, tm_last;
    logic rt_clr, rt_inc, rt_spent;
    logic ev_wip, ev_sus_ok;
    logic wait_en, end_en;
    op_t  op_out;

    assign wait_en = cur_sus ? cfg_q[B_SUS_WT]  : cfg_q[B_RES_WT];
    assign end_en  = cur_sus ? cfg_q[B_SUS_END] : cfg_q[B_RES_END];

    sr_delay_timer #(.DLY_W(DLY_W), .SH_LO(2), .SH_HI(7)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tm_load),
        .run(state == ST_HOLDOFF), .dly_val(dly_val), .x_hi(dly_x128),
        .zero_len(tm_zero), .last(tm_last)
    );

    sr_status_eval #(.STAT_W(STAT_W)) u_eval (
        .stat(stat_data), .mask(cfg_q[B_MASK_HI:B_MASK_LO]),
        .two_byte(cfg_q[B_RD2]), .is_sus(cur_sus),
        .wip(ev_wip), .sus_ok(ev_sus_ok)
    );

    sr_retry_cnt #(.LIM_W(LIM_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(rt_clr), .inc(rt_inc),
        .limit(cfg_q[B_LIM_HI:B_LIM_LO]), .spent(rt_spent)
    );

    // control word: software writes, hardware clears/sets triggers in DONE
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d = cfg_wdata;
            cfg_d[B_RSVD] = 1'b0;
            if (busy) cfg_d[B_SUS_TRG:B_RES_TRG] = cfg_q[B_SUS_TRG:B_RES_TRG];
        end
        if (state == ST_DONE) begin
            if (cur_sus) begin
                cfg_d[B_SUS_TRG] = 1'b0;
                if (cfg_q[B_CHAIN]) cfg_d[B_RES_TRG] = 1'b1;
            end else begin
                cfg_d[B_RES_TRG] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    // next-state logic
    always_comb begin
        state_nx   = state;
        cur_sus_nx = cur_sus;
        tm_load    = 1'b0;
        rt_clr     = 1'b0;
        rt_inc     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cfg_q[B_SUS_TRG] || cfg_q[B_RES_TRG]) begin
                    cur_sus_nx = cfg_q[B_SUS_TRG];
                    rt_clr     = 1'b1;
                    state_nx   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ack) begin
                    if (wait_en && !tm_zero) begin
                        tm_load  = 1'b1;
                        state_nx = ST_HOLDOFF;
                    end else begin
                        state_nx = ST_POLL_REQ;
                    end
                end
            end
            ST_HOLDOFF: begin
                if (tm_last) state_nx = ST_POLL_REQ;
            end
            ST_POLL_REQ: begin
                if (cmd_ack) state_nx = ST_POLL_WAIT;
            end
            ST_POLL_WAIT: begin
                if (stat_vld) begin
                    if (!end_en) begin
                        state_nx = ev_wip ? ST_POLL_REQ : ST_DONE;
                    end else if (ev_wip) begin
                        state_nx = ST_POLL_REQ;
                    end else if (ev_sus_ok || rt_spent) begin
                        state_nx = ST_DONE;
                    end else begin
                        rt_inc   = 1'b1;
                        state_nx = ST_POLL_REQ;
                    end
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_sus <= 1'b0;
        end else begin
            state   <= state_nx;
            cur_sus <= cur_sus_nx;
        end
    end

    // outputs
    always_comb begin
        op_out  = OP_NONE;
        cmd_req = 1'b0;
        unique case (state)
            ST_ISSUE: begin
                cmd_req = 1'b1;
                op_out  = cur_sus ? OP_SUS : OP_RES;
            end
            ST_POLL_REQ: begin
                cmd_req = 1'b1;
                op_out  = OP_RDSR;
            end
            default: ;
        endcase
    end

    assign cmd_op    = op_out;
    assign cmd_rd2   = cfg_q[B_RD2];
    assign busy      = (state != ST_IDLE);
    assign cfg_rdata = cfg_q;

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req && cmd_op == $past(cmd_op)); // R2
    AST_SUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && cfg_q[B_SUS_TRG] && cfg_q[B_RES_TRG]
        |=> cmd_req && cmd_op == OP_SUS); // R9
    AST_TRIG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (state != ST_DONE)
        |=> cfg_q[B_SUS_TRG:B_RES_TRG] == $past(cfg_q[B_SUS_TRG:B_RES_TRG])); // R10
    AST_CHAIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) && cur_sus && cfg_q[B_CHAIN] |=> cfg_q[B_RES_TRG]); // R8
    AST_HOLDOFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDOFF) |=> (state == ST_HOLDOFF) || (state == ST_POLL_REQ)); // R3
    AST_POLL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_WAIT) |-> !cmd_req); // R11
endmodule

// File: tb/flash_susres_seq_test.sv
`timescale 1ns/1ps
module flash_susres_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [9:0]  dly_val = '0;
    logic        dly_x128 = 1'b0;
    logic        cmd_req;
    logic [1:0]  cmd_op;
    logic        cmd_rd2;
    logic        cmd_ack = 1'b0;
    logic        stat_vld = 1'b0;
    logic [15:0] stat_data = '0;
    logic        busy;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    logic [15:0] resp [16];
    int resp_n = 1;
    int rd_idx = 0;
    logic [1:0] log_op [64];
    logic       log_rd2 [64];
    int         log_t [64];
    int nops = 0;
    logic stat_due = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_susres_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dly_val(dly_val), .dly_x128(dly_x128),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_rd2(cmd_rd2),
        .cmd_ack(cmd_ack), .stat_vld(stat_vld), .stat_data(stat_data),
        .busy(busy)
    );

    // flash/shifter responder
    initial begin
        forever begin
            @(negedge clk);
            cmd_ack  = 1'b0;
            stat_vld = 1'b0;
            if (stat_due) begin
                stat_vld  = 1'b1;
                stat_data = resp[(rd_idx < resp_n) ? rd_idx : resp_n - 1];
                rd_idx++;
                stat_due  = 1'b0;
            end else if (cmd_req) begin
                cmd_ack = 1'b1;
                if (nops < 64) begin
                    log_op[nops]  = cmd_op;
                    log_rd2[nops] = cmd_rd2;
                    log_t[nops]   = cyc;
                end
                nops++;
                if (cmd_op == 2'd3) stat_due = 1'b1;
            end
        end
    end

    function automatic logic [31:0] cw(input logic [6:0] lim, input logic se, re, rd2,
                                       input logic [15:0] m, input logic ch, sw, rw, st, rt);
        return {lim, se, re, rd2, m, 1'b0, ch, sw, rw, st, rt};
    endfunction

    function automatic int count_op(input logic [1:0] op);
        int n = 0;
        for (int i = 0; i < nops && i < 64; i++) if (log_op[i] == op) n++;
        return n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic prep(input int n, input logic [15:0] a, b, c, d);
        nops = 0; rd_idx = 0; resp_n = n;
        resp[0] = a; resp[1] = b; resp[2] = c; resp[3] = d;
    endtask

    task automatic wait_idle();
        while (busy || cfg_rdata[1:0] != 2'b00) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset word", cfg_rdata, 32'h0800_2000);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 cmd_req", {31'd0, cmd_req}, 0);
    endtask

    task automatic t_plain_suspend();
        prep(3, 16'h0001, 16'h0001, 16'h0000, 0);
        wr(cw(4, 0, 0, 0, 16'h0080, 0, 0, 0, 1, 0));
        chk("R2 trigger visible", {30'd0, cfg_rdata[1:0]}, 2);
        wait_idle();
        chk("R2 first op suspend", {30'd0, log_op[0]}, 1);
        chk("R5 R11 polls until WIP clear", nops, 4);
        chk("R11 poll op", {30'd0, log_op[1]}, 3);
        chk("R3 no hold-off gap", log_t[1] - log_t[0], 1);
        chk("R2 trigger cleared", cfg_rdata, cw(4, 0, 0, 0, 16'h0080, 0, 0, 0, 0, 0));
    endtask

    task automatic t_holdoff();
        prep(1, 16'h0000, 0, 0, 0);
        dly_val = 10'd3; dly_x128 = 1'b0;
        wr(cw(4, 0, 0, 0, 16'h0080, 0, 0, 1, 0, 1));
        wait_idle();
        chk("R2 resume op", {30'd0, log_op[0]}, 2);
        chk("R3 x4 hold-off", log_t[1] - log_t[0], 13);
        prep(1, 16'h0000, 0, 0, 0);
        dly_val = 10'd2; dly_x128 = 1'b1;
        wr(cw(4, 0, 0, 0, 16'h0080, 0, 1, 0, 1, 0));
        wait_idle();
        chk("R3 x128 hold-off", log_t[1] - log_t[0], 257);
        dly_val = 10'd0;
    endtask

    task automatic t_sus_mask();
        prep(4, 16'h8080, 16'h8080, 16'h0081, 16'h0000);
        wr(cw(10, 1, 0, 0, 16'h0080, 0, 0, 0, 1, 0));
        wait_idle();
        chk("R4 R6 one-byte ignores upper", count_op(3), 4);
        chk("R4 one-byte length", {31'd0, log_rd2[1]}, 0);
        prep(1, 16'h8080, 0, 0, 0);
        wr(cw(10, 1, 0, 1, 16'h0080, 0, 0, 0, 1, 0));
        wait_idle();
        chk("R4 two-byte passes", count_op(3), 1);
        chk("R4 two-byte length", {31'd0, log_rd2[1]}, 1);
    endtask

    task automatic t_res_mask();
        prep(2, 16'h0000, 16'h0080, 0, 0);
        wr(cw(10, 0, 1, 0, 16'h0080, 0, 0, 0, 0, 1));
        wait_idle();
        chk("R6 resume needs zero masked", count_op(3), 2);
    endtask

    task automatic t_retry();
        prep(1, 16'h0080, 0, 0, 0);
        wr(cw(2, 1, 0, 0, 16'h0080, 0, 0, 0, 1, 0));
        wait_idle();
        chk("R7 limit 2 gives 3 polls", count_op(3), 3);
        prep(1, 16'h0080, 0, 0, 0);
        wr(cw(0, 1, 0, 0, 16'h0080, 0, 0, 0, 1, 0));
        wait_idle();
        chk("R7 limit 0 gives 1 poll", count_op(3), 1);
        prep(1, 16'h0080, 0, 0, 0);
        wr(cw(2, 1, 0, 0, 16'h0080, 0, 0, 0, 1, 0));
        wait_idle();
        chk("R7 counter restarts", count_op(3), 3);
    endtask

    task automatic t_chain();
        prep(1, 16'h0000, 0, 0, 0);
        wr(cw(4, 0, 0, 0, 16'h0080, 1, 0, 0, 1, 0));
        wait_idle();
        chk("R8 chained op count", nops, 4);
        chk("R8 suspend first", {30'd0, log_op[0]}, 1);
        chk("R8 resume follows", {30'd0, log_op[2]}, 2);
    endtask

    task automatic t_both();
        prep(1, 16'h0000, 0, 0, 0);
        wr(cw(4, 0, 0, 0, 16'h0080, 0, 0, 0, 1, 1));
        wait_idle();
        chk("R9 suspend first", {30'd0, log_op[0]}, 1);
        chk("R9 resume second", {30'd0, log_op[2]}, 2);
    endtask

    task automatic t_busy_ignore();
        prep(6, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
        resp[4] = 16'h0001; resp[5] = 16'h0000;
        wr(cw(4, 0, 0, 0, 16'h0080, 0, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        wr(cw(4, 0, 0, 0, 16'h0040, 0, 0, 0, 1, 1));
        wait_idle();
        chk("R10 no resume started", count_op(2), 0);
        chk("R10 fields written", cfg_rdata, cw(4, 0, 0, 0, 16'h0040, 0, 0, 0, 0, 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_plain_suspend();
        t_holdoff();
        t_sus_mask();
        t_res_mask();
        t_retry();
        t_chain();
        t_both();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule